// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Read Controller

This block sits on the host side of a two-channel, simultaneous-sampling serial converter. One accepted start request runs one complete frame: an optional calibration pulse, then chip select low, a conversion phase, and a readout in which two data lines are shifted in side by side on the same serial clock edges. While the frame runs, a data-in word is shifted out to the converter. The serial clock is derived from the system clock by a programmable divider and idles high whenever chip select is high.

When the frame closes, both 14-bit results are offered on a valid/ready output. `res_valid` rises on the same system clock edge as chip select and stays high, with `res_a` and `res_b` frozen, until the consumer accepts the pair with `res_ready`. While a result is waiting, the block reports busy and starts no new frame. This is the only back-pressure path: a stalled consumer stalls conversion and no result is ever overwritten. After chip select rises, the block keeps it high for the longer of two programmable gaps before another frame may begin.

The timing counts (`half_div`, `cs_gap`, `quiet_gap`, `cal_len`) and `din_word` must be held stable while `busy` is high. `din_word` is taken when the start request is accepted.

Top module: `adc_pair_reader`

## Requirements
- R1: After reset, `adc_cs_n`=1, `adc_sclk`=1, `adc_sdi`=0, `adc_cal`=0, `busy`=0 and `res_valid`=0.
- R2: While `adc_cs_n` is high, `adc_sclk` is high. During a frame, every serial clock phase lasts exactly `half_div` system clocks (a value of 0 acts as 1). The first phase is counted from the chip select fall, so the first falling edge comes `half_div` clocks after it.
- R3: A frame has exactly 34 serial clock falling edges. Chip select rises on the rising edge that comes `half_div` clocks after the 34th fall.
- R4: The data lines are ignored at falling edges 1 to 20, which are the 19-clock conversion phase and the access edge after it. Values on those lines then have no effect on the results.
- R5: Both channels are sampled on the same falling edges. Bit b (13 = MSB) of each channel is taken at falling edge 34−b, so the MSB is first at edge 21 and bit 0 is taken at edge 34.
- R6: `adc_sdi` changes only while `adc_sclk` is high. At falling edge k (1 ≤ k ≤ 14) it carries bit 14−k of the accepted `din_word`, and it is 0 after bit 0.
- R7: Between the chip select rise and the next fall, chip select stays high for at least max(`cs_gap`, `quiet_gap`) system clocks. `busy` stays high for that gap.
- R8: When `cal_en`=1 at an accepted start, `adc_cal` goes high for `cal_len` system clocks (0 acts as 1). Chip select falls on the same edge on which `adc_cal` falls.
- R9: A start request is ignored while `busy` is high. It starts no extra frame.
- R10: `res_valid` rises with the chip select rise. It holds, with `res_a`/`res_b` stable and `busy` high, until a cycle with `res_ready`=1. No frame starts while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one frame (taken when not busy) |
| cal_en | input | 1 | Precede the frame with a calibration pulse |
| din_word | input | 14 | Word shifted out to the converter, MSB first |
| half_div | input | 8 | System clocks per serial clock phase |
| cs_gap | input | 12 | Minimum chip-select-high clocks |
| quiet_gap | input | 12 | Minimum quiet clocks after a read |
| cal_len | input | 12 | Calibration pulse length in clocks |
| res_ready | input | 1 | Consumer accepts the result pair |
| res_valid | output | 1 | Result pair available |
| res_a | output | 14 | Channel A result |
| res_b | output | 14 | Channel B result |
| busy | output | 1 | Frame, gap or pending result in progress |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdi | output | 1 | Serial data to converter |
| adc_cal | output | 1 | Calibration pulse |
| adc_do_a | input | 1 | Serial data from channel A |
| adc_do_b | input | 1 | Serial data from channel B |

## Verification
A behavioural converter model drives random bits on both data lines during the conversion phase and on the access edge, and known words inside the data window. Correct results therefore show that the window starts at the right edge and that the bit order is right. Directed words (all ones, all zeros, alternating patterns that differ between A and B) expose swapped channels and off-by-one shifts. Random divider values of 1 to 4, random gaps and random calibration lengths separate correct phase counting from an accidental fit at one setting. A start pulsed mid-frame, and a consumer that withholds ready, show that requests are dropped and results are held.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_RUN  = 2'd2,
    ST_GAP  = 2'd3
  } frame_state_e;
endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             fall_stb,
  output logic             rise_stb
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit      = ({1'b0, cnt} + 1'b1) >= {1'b0, half_div};
  assign fall_stb = run && hit && sclk;
  assign rise_stb = run && hit && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b1;
      cnt  <= '0;
    end else if (!run) begin
      sclk <= 1'b1;
      cnt  <= '0;
    end else if (hit) begin
      sclk <= ~sclk;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the clock may only go low in a cycle in which run was asserted
  assert_sclk_low_only_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(run));
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap_en,
  input  logic             frame_end,
  input  logic             do_a,
  input  logic             do_b,
  output logic [RES_W-1:0] sh_a,
  output logic [RES_W-1:0] sh_b
);
  localparam int TK_W = $clog2(RES_W + 1);

  logic [TK_W-1:0] taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a  <= '0;
      sh_b  <= '0;
      taken <= '0;
    end else if (clear) begin
      sh_a  <= '0;
      sh_b  <= '0;
      taken <= '0;
    end else if (cap_en) begin
      sh_a  <= {sh_a[RES_W-2:0], do_a};
      sh_b  <= {sh_b[RES_W-2:0], do_b};
      taken <= taken + 1'b1;
    end
  end

  // R5: a frame closes only after exactly RES_W bits per channel were taken
  assert_bits_per_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> taken == TK_W'(RES_W));
  // R4: nothing is shifted when no capture strobe is present
  assert_hold_outside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !clear |=> $stable(sh_a) && $stable(sh_b));
endmodule

// File: rtl/adcrd_sdi_shift.sv
module adcrd_sdi_shift #(
  parameter int DIN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIN_W-1:0] word,
  input  logic             rise_stb,
  output logic             sdi
);
  logic [DIN_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (load)     sr <= word;
    else if (rise_stb) sr <= {sr[DIN_W-2:0], 1'b0};
  end

  assign sdi = sr[DIN_W-1];
endmodule

// File: rtl/adcrd_frame_ctrl.sv
module adcrd_frame_ctrl
  import adcrd_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SKIP   = 20,
  parameter int N_FALL = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cal_en,
  input  logic [CNT_W-1:0] cs_gap,
  input  logic [CNT_W-1:0] quiet_gap,
  input  logic [CNT_W-1:0] cal_len,
  input  logic             fall_stb,
  input  logic             rise_stb,
  input  logic             res_ready,
  output logic             load,
  output logic             cap_en,
  output logic             frame_end,
  output logic             run,
  output logic             cs_n,
  output logic             cal,
  output logic             busy,
  output logic             res_valid
);
  localparam int FC_W = $clog2(N_FALL + 1);

  frame_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gap_lim;
  logic [FC_W-1:0]  fall_cnt;
  logic             accept, cal_hit, gap_hit;

  assign gap_lim   = (cs_gap > quiet_gap) ? cs_gap : quiet_gap;
  assign cal_hit   = ({1'b0, cnt} + 1'b1) >= {1'b0, cal_len};
  assign gap_hit   = ({1'b0, cnt} + 1'b1) >= {1'b0, gap_lim};
  assign accept    = (state == ST_IDLE) && start && !res_valid;
  assign load      = accept;
  assign run       = (state == ST_RUN);
  assign cs_n      = !run;
  assign cal       = (state == ST_CAL);
  assign busy      = (state != ST_IDLE) || res_valid;
  assign cap_en    = run && fall_stb && (fall_cnt >= FC_W'(SKIP));
  assign frame_end = run && rise_stb && (fall_cnt == FC_W'(N_FALL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      fall_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= cal_en ? ST_CAL : ST_RUN;
          cnt      <= '0;
          fall_cnt <= '0;
        end
        ST_CAL: if (cal_hit) begin
          state <= ST_RUN;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_RUN: begin
          if (fall_stb) fall_cnt <= fall_cnt + 1'b1;
          if (frame_end) begin
            state <= ST_GAP;
            cnt   <= '0;
          end
        end
        default: if (gap_hit) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_valid <= 1'b0;
    else if (frame_end) res_valid <= 1'b1;
    else if (res_ready) res_valid <= 1'b0;
  end

  // R3: chip select rises only after the full count of falling edges
  assert_falls_per_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(fall_cnt) == FC_W'(N_FALL));
  // R9: a request during a frame leaves the frame running
  assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && start && !frame_end |=> run);
endmodule

// File: rtl/adc_pair_reader.sv
module adc_pair_reader #(
  parameter int RES_W     = 14,
  parameter int DIN_W     = 14,
  parameter int CONV_CLKS = 19,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cal_en,
  input  logic [DIN_W-1:0] din_word,
  input  logic [DIV_W-1:0] half_div,
  input  logic [CNT_W-1:0] cs_gap,
  input  logic [CNT_W-1:0] quiet_gap,
  input  logic [CNT_W-1:0] cal_len,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b,
  output logic             busy,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_sdi,
  output logic             adc_cal,
  input  logic             adc_do_a,
  input  logic             adc_do_b
);
  localparam int SKIP   = CONV_CLKS + 1;
  localparam int N_FALL = SKIP + RES_W;

  logic run, fall_stb, rise_stb, load, cap_en, frame_end;

  adcrd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
    .sclk(adc_sclk), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  adcrd_frame_ctrl #(.CNT_W(CNT_W), .SKIP(SKIP), .N_FALL(N_FALL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cal_en(cal_en),
    .cs_gap(cs_gap), .quiet_gap(quiet_gap), .cal_len(cal_len),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .res_ready(res_ready),
    .load(load), .cap_en(cap_en), .frame_end(frame_end), .run(run),
    .cs_n(adc_cs_n), .cal(adc_cal), .busy(busy), .res_valid(res_valid)
  );

  adcrd_capture #(.RES_W(RES_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(load), .cap_en(cap_en),
    .frame_end(frame_end), .do_a(adc_do_a), .do_b(adc_do_b),
    .sh_a(res_a), .sh_b(res_b)
  );

  adcrd_sdi_shift #(.DIN_W(DIN_W)) u_sdi (
    .clk(clk), .rst_n(rst_n), .load(load), .word(din_word),
    .rise_stb(rise_stb), .sdi(adc_sdi)
  );

  // R2: serial clock idles high whenever the converter is deselected
  assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);
  // R6: data-in moves only while the serial clock is high
  assert_sdi_moves_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_sdi) |-> adc_sclk);
  // R8: calibration ends exactly as chip select falls
  assert_cal_then_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cal) |-> $fell(adc_cs_n));
  // R10: a pending result is held until accepted
  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && busy && $stable(res_a) && $stable(res_b));
endmodule

// File: tb/adc_pair_reader_bench.sv
module adc_pair_reader_bench;
  localparam int RES_W  = 14;
  localparam int DIN_W  = 14;
  localparam int SKIP   = 20;
  localparam int N_FALL = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cal_en = 1'b0, res_ready = 1'b0;
  logic [DIN_W-1:0] din_word = '0;
  logic [7:0]  half_div = 8'd2;
  logic [11:0] cs_gap = 12'd4, quiet_gap = 12'd4, cal_len = 12'd3;
  logic res_valid, busy, adc_cs_n, adc_sclk, adc_sdi, adc_cal;
  logic [RES_W-1:0] res_a, res_b;
  logic adc_do_a = 1'b0, adc_do_b = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_pair_reader u_adc_pair_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cal_en(cal_en), .din_word(din_word),
    .half_div(half_div), .cs_gap(cs_gap), .quiet_gap(quiet_gap), .cal_len(cal_len),
    .res_ready(res_ready), .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
    .busy(busy), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdi(adc_sdi),
    .adc_cal(adc_cal), .adc_do_a(adc_do_a), .adc_do_b(adc_do_b)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // behavioural converter: drives window bits, noise elsewhere
  logic [RES_W-1:0] m_a = '0, m_b = '0;
  int mfall = 0;
  always @(negedge adc_cs_n) mfall = 0;
  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      mfall++;
      #1;
      if (mfall >= SKIP && mfall < N_FALL) begin
        adc_do_a = m_a[N_FALL-1-mfall];
        adc_do_b = m_b[N_FALL-1-mfall];
      end else begin
        adc_do_a = $urandom() % 2 == 1;
        adc_do_b = $urandom() % 2 == 1;
      end
    end
  end

  // port monitor
  logic p_cs = 1'b1, p_sclk = 1'b1, p_sdi = 1'b0, p_cal = 1'b0;
  int hp = 0, falls = 0, cs_hi = 0, cal_hi = 0, frames = 0;
  int cur_h = 1, gap_exp = 0, exp_cal = 1;
  bit hp_bad = 0, sdi_bad = 0, idle_bad = 0;
  logic [DIN_W-1:0] cur_din = '0, tb_din = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_cs_n && !adc_sclk) idle_bad = 1;
      if (!p_cal && adc_cal) begin
        cal_hi = 0;
        exp_cal = max2(1, int'(cal_len));
      end
      if (adc_cal) cal_hi++;
      if (p_cal && !adc_cal)
        chk(cal_hi >= exp_cal && p_cs && !adc_cs_n, "R8 cal width / cs fall", cal_hi, exp_cal);
      if (p_cs && !adc_cs_n) begin
        frames++;
        if (frames > 1) chk(cs_hi > gap_exp, "R7 cs high gap", cs_hi, gap_exp);
        hp = 0; falls = 0; hp_bad = 0; sdi_bad = 0;
        cur_h = max2(1, int'(half_div));
        cur_din = tb_din;
      end else if (!p_cs) begin
        hp++;
        if (adc_sdi != p_sdi && !adc_sclk) sdi_bad = 1;
        if (adc_sclk != p_sclk) begin
          if (hp != cur_h) hp_bad = 1;
          hp = 0;
          if (!adc_sclk) begin
            falls++;
            if (falls <= DIN_W) begin
              if (p_sdi != cur_din[DIN_W-falls]) sdi_bad = 1;
            end else if (p_sdi != 1'b0) sdi_bad = 1;
          end
        end
        if (adc_cs_n) begin
          chk(falls == N_FALL, "R3 falls per frame", falls, N_FALL);
          chk(!hp_bad, "R2 phase lengths", hp_bad, 0);
          chk(!sdi_bad, "R6 sdi bits/timing", sdi_bad, 0);
          chk(res_valid, "R10 valid with cs rise", res_valid, 1);
          gap_exp = max2(int'(cs_gap), int'(quiet_gap));
          cs_hi = 0;
        end
      end
      if (adc_cs_n) cs_hi++;
      p_cs = adc_cs_n; p_sclk = adc_sclk; p_sdi = adc_sdi; p_cal = adc_cal;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic frame(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b,
                       input logic [DIN_W-1:0] d, input bit cal, input int h,
                       input int g1, input int g2, input int cl, input bit poke);
    int f0;
    wait_idle();
    @(negedge clk);
    half_div = 8'(h); cs_gap = 12'(g1); quiet_gap = 12'(g2); cal_len = 12'(cl);
    cal_en = cal; din_word = d; tb_din = d; m_a = a; m_b = b;
    f0 = frames;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      while (adc_cs_n) @(negedge clk);
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!res_valid) @(negedge clk);
    chk(res_a == a, "R5 R4 channel A result", int'(res_a), int'(a));
    chk(res_b == b, "R5 R4 channel B result", int'(res_b), int'(b));
    if (poke) begin
      // R10: withheld ready keeps result and blocks requests
      start = 1'b1;
      repeat (20) @(negedge clk);
      start = 1'b0;
      chk(res_valid && busy && adc_cs_n, "R10 held while not ready", res_valid, 1);
      chk(res_a == a && res_b == b, "R10 result stable", int'(res_a), int'(a));
    end
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;
    chk(!res_valid, "R10 cleared on ready", res_valid, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(frames == f0 + 1, "R9 one frame per accepted start", frames - f0, 1);
  endtask

  initial begin
    int r;
    r = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n && adc_sclk && !adc_sdi && !adc_cal && !busy && !res_valid,
        "R1 reset state", {adc_cs_n, adc_sclk, adc_sdi, adc_cal, busy, res_valid}, 6'b110000);
    frame(14'h3FFF, 14'h0000, 14'h2AAA, 1'b0, 1, 0, 0, 1, 1'b0);
    frame(14'h2AAA, 14'h1555, 14'h3FFF, 1'b1, 2, 7, 3, 5, 1'b0);
    frame(14'h0001, 14'h2000, 14'h0001, 1'b0, 3, 2, 9, 1, 1'b1);
    frame(14'h1234, 14'h0F0F, 14'h1555, 1'b1, 1, 0, 0, 0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      frame(14'($urandom()), 14'($urandom()), 14'($urandom()), ($urandom() % 2) == 1,
            1 + int'($urandom() % 4), int'($urandom() % 16), int'($urandom() % 16),
            1 + int'($urandom() % 10), i == 3);
    end
    chk(!idle_bad, "R2 sclk high while deselected", idle_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule